// File: doc/BRIEF.md
# Sweep-Scaled Calibrator Divider

This block makes the square-wave timing signal for an oscilloscope calibrator. It divides a timing tick by a ratio set by the sweep-speed code, so that two sweep divisions always make one calibrator period and five full cycles span a ten-division trace. The tick enable runs at twice the top output frequency: a 10 MHz tick rate gives a 5 MHz square wave when the output toggles on every tick. Each half period lasts h ticks. The value of h follows the 1-2-5 sweep sequence.

The speed code is an index in which larger values mean faster sweeps. Codes at or below `SLOW_CODE` hold the slowest output, which is 5 Hz with the default six decades. Codes at or above `SLOW_CODE + 3*DECADES` hold the fastest output, 5 MHz. When vertical channels are chopped and sweeps are running, every second end-of-sweep strobe freezes the divider for `SKEW_TICKS` ticks, which is 200 ns by default. This breaks up any lock between the chop rate and the sweep.

Top module: `calib_divider`

## Requirements
- R1: While reset is active and after it is released, `cal_out` is low. The first rising transition comes exactly h ticks after release, where h is the half-period count for the current code.
- R2: `cal_out` changes only in cycles where `tick_en` is high. Between skews, every high phase and every low phase lasts exactly h ticks.
- R3: For a code c with SLOW_CODE < c < FAST_CODE, where FAST_CODE = SLOW_CODE + 3*DECADES, take s = FAST_CODE - c. Then h = m * 10^(s/3), with m equal to 1, 2 or 5 when s mod 3 is 0, 1 or 2.
- R4: Any code at or below SLOW_CODE gives h = 10^DECADES, the slow limit.
- R5: Any code at or above FAST_CODE gives h = 1, so the output toggles on every tick.
- R6: An end-of-sweep strobe qualifies when `chop_mode`=1 and `single_seq`=0. Qualifying strobes alternate, starting after reset with one that adds no skew. Each second qualifying strobe lengthens the phase in progress by SKEW_TICKS ticks.
- R7: A strobe with `chop_mode`=0 or `single_seq`=1 changes neither the output timing nor the alternation of R6.
- R8: During a skew, `cal_out` holds its level through the stalled ticks.
- R9: If the speed code changes to a value whose h is at or below the number of ticks already counted in the current phase, the output toggles on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timing tick enable, twice the top output rate |
| speed_code | input | CODE_W (5) | Sweep-speed index, larger is faster |
| chop_mode | input | 1 | Vertical channels are chopped |
| single_seq | input | 1 | Single-sequence mode, no sweeps running |
| sweep_end | input | 1 | One-cycle end-of-sweep strobe |
| cal_out | output | 1 | Calibrator square wave |

## Verification
The bench measures the length of each output phase in ticks while the tick enable runs both back to back and at a random duty. This separates tick counting from clock counting. It steps through every in-range code, codes beyond both limits and random codes, so a wrong mantissa, decade or clamp boundary shows up as a wrong phase length. Strobes are issued under chop, chop-off and single-sequence settings. The bench tracks its own alternation parity, so a missing skew, a skew on the wrong strobe or a parity flip caused by an ignored strobe each give a phase that is SKEW_TICKS off. A mid-phase switch from a slow code to the fastest code checks that the new ratio takes effect at once.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic {
    PH_PLAIN = 1'b0,
    PH_SKEW  = 1'b1
  } skew_phase_e;

  function automatic int unsigned step_mantissa(input int unsigned rem);
    case (rem)
      0:       return 1;
      1:       return 2;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/cal_ratio_sel.sv
module cal_ratio_sel #(
  parameter int CODE_W    = 5,
  parameter int DECADES   = 6,
  parameter int SLOW_CODE = 2,
  parameter int HW        = 20
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [HW-1:0]     half_o
);
  localparam int unsigned MAX_STEP  = 3 * DECADES;
  localparam int unsigned FAST_CODE = SLOW_CODE + MAX_STEP;

  function automatic logic [HW-1:0] calc_half(input int unsigned st);
    int unsigned v;
    v = cal_pkg::step_mantissa(st % 3);
    for (int d = 0; d < DECADES; d++) begin
      if (d < int'(st / 3)) v = v * 10;
    end
    return HW'(v);
  endfunction

  int unsigned code_u;
  int unsigned step;

  always_comb begin
    code_u = 32'(code_i);
    if (code_u <= SLOW_CODE)      step = MAX_STEP;
    else if (code_u >= FAST_CODE) step = 0;
    else                          step = FAST_CODE - code_u;
    half_o = calc_half(step);
  end

endmodule

// File: rtl/cal_skew_ctl.sv
module cal_skew_ctl #(
  parameter int SKEW_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic chop_i,
  input  logic sgl_i,
  input  logic eos_i,
  output logic stall_o
);
  import cal_pkg::*;

  localparam int SW = $clog2(SKEW_TICKS + 1);

  skew_phase_e phase_q, phase_d;
  logic [SW-1:0] stall_q, stall_d;
  logic qual;
  logic stall_en;

  assign qual    = eos_i && chop_i && !sgl_i;
  assign stall_o = (stall_q != '0);

  always_comb begin
    phase_d  = phase_q;
    stall_d  = stall_q;
    stall_en = 1'b0;
    if (qual) begin
      phase_d = (phase_q == PH_PLAIN) ? PH_SKEW : PH_PLAIN;
      if (phase_q == PH_SKEW) begin
        stall_d  = SW'(SKEW_TICKS);
        stall_en = 1'b1;
      end
    end
    if (!stall_en && tick_i && stall_o) begin
      stall_d  = stall_q - 1'b1;
      stall_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PLAIN;
      stall_q <= '0;
    end else begin
      if (qual)     phase_q <= phase_d;
      if (stall_en) stall_q <= stall_d;
    end
  end

  // R7: a strobe that does not qualify starts no skew and keeps the phase
  p_ignore_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_i && !(chop_i && !sgl_i) && !stall_o) |=> (!stall_o && $stable(phase_q)));

  // R6: a qualifying strobe in the skew phase starts a stall
  p_skew_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && phase_q == PH_SKEW) |=> stall_o);

endmodule

// File: rtl/cal_half_div.sv
module cal_half_div #(
  parameter int HW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          stall_i,
  input  logic [HW-1:0] half_i,
  output logic          cal_o
);
  logic [HW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic          adv;

  assign adv   = tick_i && !stall_i;
  assign cal_o = out_q;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (cnt_q >= half_i - 1'b1) begin
      cnt_d = '0;
      out_d = ~out_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (adv) begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  // R2: the output moves only on a tick
  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cal_o));

  // R8: the output holds while the skew stalls the divider
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(cal_o));

endmodule

// File: rtl/calib_divider.sv
module calib_divider #(
  parameter int CODE_W     = 5,
  parameter int DECADES    = 6,
  parameter int SLOW_CODE  = 2,
  parameter int SKEW_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] speed_code,
  input  logic              chop_mode,
  input  logic              single_seq,
  input  logic              sweep_end,
  output logic              cal_out
);
  localparam int HW        = $clog2(10 ** DECADES + 1);
  localparam int FAST_CODE = SLOW_CODE + 3 * DECADES;

  logic          rst_meta_q, rst_sync_q;
  logic [HW-1:0] half;
  logic          stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cal_ratio_sel #(
    .CODE_W(CODE_W), .DECADES(DECADES), .SLOW_CODE(SLOW_CODE), .HW(HW)
  ) u_ratio (
    .code_i(speed_code),
    .half_o(half)
  );

  cal_skew_ctl #(.SKEW_TICKS(SKEW_TICKS)) u_skew (
    .clk(clk), .rst_n(rst_sync_q), .tick_i(tick_en), .chop_i(chop_mode),
    .sgl_i(single_seq), .eos_i(sweep_end), .stall_o(stall)
  );

  cal_half_div #(.HW(HW)) u_div (
    .clk(clk), .rst_n(rst_sync_q), .tick_i(tick_en), .stall_i(stall),
    .half_i(half), .cal_o(cal_out)
  );

  // R5: at the fast limit every unstalled tick flips the output
  p_fast_toggle_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (tick_en && !stall && 32'(speed_code) >= FAST_CODE) |=> (cal_out != $past(cal_out)));

  // R1: the output is low while the internal reset is held
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_sync_q |-> !cal_out);

endmodule

// File: tb/calib_divider_test.sv
module calib_divider_test;
  localparam int CW   = 5;
  localparam int DEC  = 2;
  localparam int SLOW = 2;
  localparam int SKEW = 2;
  localparam int FAST = SLOW + 3 * DEC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [CW-1:0] spd = '0;
  logic chop = 1'b0;
  logic sgl = 1'b0;
  logic eos = 1'b0;
  logic cal;

  int errs = 0;
  int checks = 0;
  int toggles = 0;
  int ticks_since = 0;
  int last_iv = 0;
  int duty = 100;
  int qcount = 0;
  logic tick_seen = 1'b0;
  logic prev_cal = 1'b0;

  always #10 clk = ~clk;

  calib_divider #(.CODE_W(CW), .DECADES(DEC), .SLOW_CODE(SLOW), .SKEW_TICKS(SKEW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .speed_code(spd), .chop_mode(chop),
    .single_seq(sgl), .sweep_end(eos), .cal_out(cal)
  );

  always @(posedge clk) tick_seen <= tick;

  always @(negedge clk) begin
    if (!rst_n) begin
      ticks_since = 0;
      prev_cal = cal;
    end else begin
      if (tick_seen) ticks_since = ticks_since + 1;
      if (cal !== prev_cal) begin
        last_iv = ticks_since;
        ticks_since = 0;
        toggles = toggles + 1;
      end
      prev_cal = cal;
    end
  end

  function automatic int exp_half(input int code);
    int st, v;
    if (code <= SLOW) st = 3 * DEC;
    else if (code >= FAST) st = 0;
    else st = FAST - code;
    v = (st % 3 == 0) ? 1 : (st % 3 == 1) ? 2 : 5;
    for (int d = 0; d < st / 3; d++) v = v * 10;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_toggle();
    int start;
    start = toggles;
    forever begin
      @(negedge clk); #1;
      if (toggles != start) break;
      tick = (($urandom % 100) < duty);
    end
  endtask

  // issue a strobe right after a toggle, with no tick in the strobe cycle
  task automatic strobe(output int skew);
    tick = 1'b0;
    eos = 1'b1;
    skew = 0;
    if (chop && !sgl) begin
      if (qcount % 2 == 1) skew = SKEW;
      qcount++;
    end
    @(negedge clk); #1;
    eos = 1'b0;
  endtask

  task automatic measure(input string req, input int code, input int extra);
    wait_toggle();
    chk(req, last_iv, exp_half(code) + extra);
  endtask

  task automatic set_code(input int code);
    spd = CW'(code);
    wait_toggle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    int sk;
    int start;
    seed = $urandom(32'd2024);
    spd = CW'(SLOW + 2);
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset level", int'(cal), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 low after release", int'(cal), 0);
    duty = 100;
    tick = 1'b1;
    wait_toggle();
    chk("R1 first phase length", last_iv, exp_half(SLOW + 2));
    chk("R1 first edge rises", int'(cal), 1);

    // R3: every in-range code, both phases
    for (int c = SLOW + 1; c < FAST; c++) begin
      set_code(c);
      measure("R3 high/low phase", c, 0);
      measure("R3 next phase", c, 0);
    end
    // R4 and R5 clamps
    for (int c = 0; c <= SLOW; c++) begin
      set_code(c);
      measure("R4 slow clamp", c, 0);
    end
    set_code(FAST);
    measure("R5 fast limit", FAST, 0);
    set_code(31);
    measure("R5 beyond fast", 31, 0);
    measure("R5 beyond fast again", 31, 0);

    // R2 with gapped ticks
    duty = 35;
    set_code(SLOW + 4);
    measure("R2 gapped ticks", SLOW + 4, 0);
    measure("R2 gapped ticks other phase", SLOW + 4, 0);
    duty = 100;

    // R6: alternating skew with chop on
    chop = 1'b1;
    sgl = 1'b0;
    set_code(SLOW + 5);
    for (int k = 0; k < 4; k++) begin
      strobe(sk);
      measure("R6 strobe phase", SLOW + 5, sk);
    end

    // R7: ignored strobes, then alternation resumes where it stood
    sgl = 1'b1;
    for (int k = 0; k < 3; k++) begin
      strobe(sk);
      measure("R7 single-seq strobe", SLOW + 5, 0);
    end
    sgl = 1'b0;
    chop = 1'b0;
    for (int k = 0; k < 3; k++) begin
      strobe(sk);
      measure("R7 chop-off strobe", SLOW + 5, 0);
    end
    chop = 1'b1;
    strobe(sk);
    measure("R7 parity kept, no skew", SLOW + 5, 0);
    strobe(sk);
    measure("R7 parity kept, skew", SLOW + 5, SKEW);

    // R8: at the fast limit a skew holds the level through stalled ticks
    set_code(FAST);
    strobe(sk);
    measure("R8 plain strobe", FAST, sk);
    strobe(sk);
    measure("R8 held through stall", FAST, sk);
    chop = 1'b0;

    // R9: switch to fast mid-phase
    set_code(SLOW + 1);
    wait_toggle();
    start = toggles;
    tick = 1'b1;
    repeat (10) begin @(negedge clk); #1; end
    chk("R9 no early toggle", toggles, start);
    spd = CW'(FAST);
    @(negedge clk); #1;
    chk("R9 toggles on next tick", toggles, start + 1);
    chk("R9 phase length", last_iv, 11);

    // random mix
    for (int t = 0; t < 30; t++) begin
      int code;
      code = int'($urandom % 32);
      duty = 30 + int'($urandom % 71);
      chop = 1'($urandom % 2);
      sgl = 1'($urandom % 2);
      set_code(code);
      if ($urandom % 2 == 1) strobe(sk);
      else sk = 0;
      measure("R3/R6 random phase", code, sk);
      measure("R2 random next phase", code, 0);
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule